// File: doc/BRIEF.md
# Wavetable Tone Generator

This block makes a stream of signed 16-bit audio samples for a tone whose pitch is set by a frequency input in hertz. It keeps a 32-bit phase accumulator. For each sample, the upper address bits of that phase pick one entry from a single-period waveform table. The table holds one period of a triangle wave. Its address is captured in a register, so each lookup takes one clock. When the frequency input is zero, the block emits silence.

Samples leave through a valid/take handshake. A downstream consumer, a FIFO or a pipeline register can pull samples at any pace. The phase moves forward only when a sample is actually taken. The tone stays at the right pitch no matter how fast the consumer pulls, provided it pulls at the configured sample rate.

Top module: `wavetable_tone_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `valid_o` is low. In the next cycle `valid_o` is high and presents the sample for phase zero, which is table entry 0 (value 0). This sample is forced to 0 if the frequency was zero.
- R2: Each accepted sample (`valid_o` and `take_i` high at a clock edge) adds an increment to the phase. The increment is floor(freq × 2^32 / SAMPLE_HZ) taken modulo 2^32, and the phase wraps modulo 2^32. The next sample is the table entry at the top ADDR_W bits of the updated phase.
- R3: Let a be the table address and Q = 2^(ADDR_W-2) = 128. The entry is a·S for a < Q, (2Q−a)·S for Q ≤ a < 3Q, and (a−4Q)·S for a ≥ 3Q, where S = floor(32767 / Q) = 255.
- R4: An address at or above TBL_DEPTH has no table entry and reads as 0.
- R5: A sample fetched while `freq_i` is zero is 0. The phase does not move while the frequency is zero, so the next nonzero tone resumes from the same phase.
- R6: After an accepted sample, `valid_o` is low for exactly one cycle, which is the table latency. It is then high again with the next sample.
- R7: While `valid_o` is high and `take_i` is low, `valid_o` stays high and `sample_o` stays unchanged.
- R8: A change of frequency does not reset the phase. The next increment uses the new frequency and starts from the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| freq_i | input | FREQ_W (16) | Tone frequency in Hz; 0 means silence |
| take_i | input | 1 | Consumer accepts the presented sample |
| valid_o | output | 1 | A sample is being presented |
| sample_o | output | DATA_W (16) | Signed sample value |

## Verification
The assertions assume that `take_i` only matters while `valid_o` is high. They also assume that `freq_i` is sampled at the fetch edge, the cycle in which `valid_o` is low. The stimulus changes the frequency only while a sample is being presented. As a result, the silence flag and the phase step of every sample come from a single, known frequency value. A second instance has a shortened table, so the bench can reach the empty address range. The bench sweeps frequencies from zero up to the full 16-bit range, and a reference phase model predicts each sample arithmetically.

// File: rtl/wavetable_tone_gen.sv
module wavetable_tone_gen #(
  parameter int SAMPLE_HZ = 43400,
  parameter int FREQ_W    = 16,
  parameter int PHASE_W   = 32,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int TBL_DEPTH = 512
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [FREQ_W-1:0]        freq_i,
  input  logic                     take_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sample_o
);

  localparam int QUARTER = 2 ** (ADDR_W - 2);
  localparam int STEP    = (2 ** (DATA_W - 1) - 1) / QUARTER;
  localparam int PROD_W  = FREQ_W + PHASE_W;

  logic [PHASE_W-1:0] phase;
  logic [ADDR_W-1:0]  addr_q;
  logic               mute_q;
  logic               fetch;
  logic [PROD_W-1:0]  scaled;
  logic [PHASE_W-1:0] incr;
  logic               accept;

  assign scaled = {freq_i, {PHASE_W{1'b0}}} / PROD_W'(SAMPLE_HZ);
  assign incr   = scaled[PHASE_W-1:0];
  assign accept = valid_o & take_i;

  function automatic logic [DATA_W-1:0] wave(input logic [ADDR_W-1:0] a);
    int ai;
    int v;
    ai = int'(a);
    if (ai >= TBL_DEPTH)        v = 0;
    else if (ai < QUARTER)      v = ai * STEP;
    else if (ai < 3 * QUARTER)  v = (2 * QUARTER - ai) * STEP;
    else                        v = (ai - 4 * QUARTER) * STEP;
    return v[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase   <= '0;
      addr_q  <= '0;
      mute_q  <= 1'b1;
      valid_o <= 1'b0;
      fetch   <= 1'b1;
    end else if (accept) begin
      phase   <= phase + incr;
      valid_o <= 1'b0;
      fetch   <= 1'b1;
    end else if (fetch) begin
      addr_q  <= phase[PHASE_W-1 -: ADDR_W];
      mute_q  <= (freq_i == '0);
      valid_o <= 1'b1;
      fetch   <= 1'b0;
    end
  end

  assign sample_o = mute_q ? '0 : signed'(wave(addr_q));

  a_r1_reset_idle: assert property (@(posedge clk_i)
    $past(rst_i) |-> !valid_o);

  a_r6_one_cycle_gap: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && take_i) |=> !valid_o);

  a_r6_refill: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |=> valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !take_i) |=> (valid_o && $stable(sample_o)));

  a_r5_silence: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_o && freq_i == '0) |=> (sample_o == '0));

  a_r2_phase_only_on_accept: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_o && take_i) |=> $stable(phase));

endmodule

// File: tb/tb_wavetable_tone_gen.sv
module tb_wavetable_tone_gen;
  localparam int RATE = 43400;
  localparam int SHORT_DEPTH = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] freq = '0;
  logic take = 1'b0;
  logic valid_a, valid_b;
  logic signed [15:0] samp_a, samp_b;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_phase;
  bit m_mute;
  bit done = 0;

  always #2.5 clk = ~clk;

  wavetable_tone_gen #(.SAMPLE_HZ(RATE)) dut (
    .clk_i(clk), .rst_i(rst), .freq_i(freq), .take_i(take),
    .valid_o(valid_a), .sample_o(samp_a));

  wavetable_tone_gen #(.SAMPLE_HZ(RATE), .TBL_DEPTH(SHORT_DEPTH)) dut_short (
    .clk_i(clk), .rst_i(rst), .freq_i(freq), .take_i(take),
    .valid_o(valid_b), .sample_o(samp_b));

  function automatic logic [31:0] inc_of(input int f);
    logic [63:0] p;
    p = (64'(f) << 32) / 64'(RATE);
    return p[31:0];
  endfunction

  function automatic int wave_of(input int a, input int depth);
    if (a >= depth) return 0;
    if (a < 128) return a * 255;
    if (a < 384) return (256 - a) * 255;
    return (a - 512) * 255;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_sample(input string req);
    int a;
    a = int'(m_phase[31:23]);
    chk({req, " valid"}, int'(valid_a), 1);
    chk({req, " sample"}, int'(samp_a), m_mute ? 0 : wave_of(a, 512));
    chk({req, " short-table sample"}, int'(samp_b), m_mute ? 0 : wave_of(a, SHORT_DEPTH));
  endtask

  task automatic step(input string req);
    chk_sample(req);
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
    m_phase = m_phase + inc_of(int'(freq));
    m_mute = (freq == '0);
    chk("R6 gap after accept", int'(valid_a), 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(valid_a), 0);
    rst = 1'b0;
    m_phase = '0;
    m_mute = (freq == '0);
    chk("R1 valid low after release", int'(valid_a), 0);
    @(negedge clk);
    chk_sample("R1 first sample");
  endtask

  initial begin
    int freqs[9] = '{0, 1, 85, 440, 1000, 5000, 21700, 43399, 65535};
    @(negedge clk);
    freq = 16'd440;
    do_reset();
    foreach (freqs[i]) begin
      freq = 16'(freqs[i]);
      for (int k = 0; k < 120; k++) step(freqs[i] == 0 ? "R5 silence" : "R2 R3 R4 sweep");
    end
    freq = 16'd85;
    for (int k = 0; k < 520; k++) step("R4 R3 slow walk");
    for (int k = 0; k < 6; k++) begin
      logic signed [15:0] held;
      held = samp_a;
      repeat (3) begin
        @(negedge clk);
        chk("R7 valid held", int'(valid_a), 1);
        chk("R7 sample held", int'(samp_a), int'(held));
      end
      step("R7 after hold");
    end
    for (int k = 0; k < 40; k++) begin
      freq = 16'((k % 4 == 3) ? 0 : 300 + 700 * k);
      step("R8 R5 frequency change");
    end
    freq = 16'd0;
    do_reset();
    step("R1 R5 silent after reset");
    freq = 16'd2000;
    for (int k = 0; k < 30; k++) step("R1 R2 after reset");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule